// File: doc/BRIEF.md
# Flash Line Prefetch Buffer Controller

This block connects a 64-bit system bus slave port to a flash array whose read port delivers a whole 256-bit line per access. It keeps two line buffers, each with its own tag and valid flag. A bus read whose line is already buffered is answered at once. A read that misses fetches the line from the array, stores it in a buffer and then answers the bus. Each buffer answer can also start a fetch of the next sequential line into the other buffer, so that code or data streaming through ascending addresses keeps hitting.

Two filters decide whether a bus access may start a prefetch. The first limits prefetching to accesses that carry one chosen master ID. The second separately allows or blocks prefetching for instruction fetches and for data reads. An invalidate strobe drops the contents of both buffers, for example after the array has been rewritten. The array port handles one read at a time. A demand miss that arrives while a prefetch is in flight waits for that prefetch to land. If the prefetch was for the requested line, the miss is answered from that buffer without a second array read.

Top module: `flash_line_prefetch`

## Requirements
- R1: A read whose line is valid in a buffer is acknowledged, with its data, in the cycle after the request is first presented (zero wait states).
- R2: Address bits [4:3] select the 64-bit word within the line (word n occupies bits 64n+63..64n of the line), and bits [31:5] form the line tag driven on the array line output.
- R3: A read that misses, with the array port idle, issues one array read of its line and is acknowledged with 3 wait states when the array returns data in the cycle after the read strobe.
- R4: Each buffer answer whose access passes the prefetch filters, while the array port is idle, issues an array read of the next line (tag + 1) in the same cycle as the acknowledge.
- R5: No prefetch read is issued when the next line is already valid in a buffer.
- R6: With the single-master restriction on, only accesses whose master ID equals the configured ID start a prefetch.
- R7: Instruction accesses start a prefetch only when instruction prefetch is enabled, and data accesses only when data prefetch is enabled. With both disabled, no prefetch is issued.
- R8: A demand miss that meets an outstanding array read waits for it to finish. If that read was for the requested line, the miss is answered from it with no further array read. Otherwise the demand read starts only after the fill.
- R9: A demand miss replaces the least recently answered buffer, and a prefetch fills the buffer other than the one that just answered.
- R10: The invalidate input clears both valid flags in one cycle, so the next read of a previously buffered line misses and returns fresh array data.
- R11: After reset no acknowledge and no array read are driven, and both buffers are empty.
- R12: The acknowledge is a single-cycle pulse, and at most one array read is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Read request, held until acknowledged |
| bus_addr | input | ADDR_W | Byte address of the read |
| bus_master | input | MID_W | ID of the requesting master |
| bus_instr | input | 1 | 1 for an instruction fetch, 0 for a data read |
| bus_ack | output | 1 | One-cycle acknowledge, valid with bus_rdata |
| bus_rdata | output | BUS_W | Read data word |
| pf_instr_en | input | 1 | Allow instruction accesses to start prefetches |
| pf_data_en | input | 1 | Allow data accesses to start prefetches |
| pf_one_master | input | 1 | Restrict prefetch starts to one master |
| pf_master_id | input | MID_W | Master allowed when the restriction is on |
| inval | input | 1 | Drop both buffers |
| arr_rd | output | 1 | One-cycle array read strobe |
| arr_line | output | ADDR_W-5 | Line tag to read |
| arr_valid | input | 1 | Array data valid |
| arr_rdata | input | LINE_W | Array line data |

## Verification
The two functions that can fall in the same cycle are a prefetch fill landing in one buffer and a demand lookup for a different or identical line. The bench provokes this by presenting a request on the very negative edge at which the previous acknowledge is seen, so the new lookup meets the in-flight prefetch that the acknowledge started. When the request targets the prefetched line, the bench expects two wait states and no extra array read. When the request targets an unrelated line, the bench expects five wait states and the demand read to follow the fill. A second overlap, an invalidate that meets buffer contents, is judged by the forced miss and the changed data pattern that follow.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam int NBUF = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DEMAND = 2'd1,
    ST_REPLY  = 2'd2
  } fpb_state_e;
endpackage

// File: rtl/fpb_line_store.sv
module fpb_line_store
  import fpb_pkg::*;
#(
  parameter int LINE_W = 256,
  parameter int BUS_W  = 64,
  parameter int TAG_W  = 27
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [TAG_W-1:0]             lk_tag,
  input  logic [TAG_W-1:0]             nx_tag,
  output logic                         hit,
  output logic                         hit_idx,
  output logic                         nx_hit,
  input  logic                         rd_idx,
  input  logic [$clog2(LINE_W/BUS_W)-1:0] rd_sel,
  output logic [BUS_W-1:0]             rd_word,
  input  logic                         iss_en,
  input  logic                         iss_idx,
  input  logic [TAG_W-1:0]             iss_tag,
  input  logic                         fill_en,
  input  logic                         fill_idx,
  input  logic                         fill_keep,
  input  logic [LINE_W-1:0]            fill_data,
  input  logic                         inval,
  output logic [NBUF-1:0]              vld
);
  logic [LINE_W-1:0] mem_q [NBUF];
  logic [TAG_W-1:0]  tag_q [NBUF];
  logic [NBUF-1:0]   vld_q;
  logic [NBUF-1:0]   match;
  logic [NBUF-1:0]   nmatch;

  // data storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (fill_en) mem_q[fill_idx] <= fill_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < NBUF; i++) tag_q[i] <= '0;
    end else begin
      if (iss_en) begin
        vld_q[iss_idx] <= 1'b0;
        tag_q[iss_idx] <= iss_tag;
      end
      if (fill_en) vld_q[fill_idx] <= fill_keep;
      if (inval) vld_q <= '0;
    end
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_cmp
    assign match[g]  = vld_q[g] && (tag_q[g] == lk_tag);
    assign nmatch[g] = vld_q[g] && (tag_q[g] == nx_tag);
  end

  assign hit     = |match;
  assign hit_idx = match[1];
  assign nx_hit  = |nmatch;
  assign rd_word = mem_q[rd_idx][rd_sel*BUS_W +: BUS_W];
  assign vld     = vld_q;
endmodule

// File: rtl/fpb_pf_filter.sv
module fpb_pf_filter #(
  parameter int MID_W = 2
) (
  input  logic [MID_W-1:0] master,
  input  logic             is_instr,
  input  logic             cfg_instr_en,
  input  logic             cfg_data_en,
  input  logic             cfg_one_master,
  input  logic [MID_W-1:0] cfg_master,
  output logic             pf_ok
);
  logic type_ok;
  logic master_ok;

  assign type_ok   = is_instr ? cfg_instr_en : cfg_data_en;
  assign master_ok = !cfg_one_master || (master == cfg_master);
  assign pf_ok     = type_ok && master_ok;
endmodule

// File: rtl/fpb_seq_ctrl.sv
module fpb_seq_ctrl
  import fpb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 64,
  parameter int LINE_W = 256,
  localparam int OFS_W  = $clog2(LINE_W/8),
  localparam int BYTE_W = $clog2(BUS_W/8),
  localparam int SEL_W  = OFS_W - BYTE_W,
  localparam int TAG_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pf_ok,
  input  logic              inval,
  input  logic              hit,
  input  logic              hit_idx,
  input  logic              nx_hit,
  input  logic [BUS_W-1:0]  rd_word,
  input  logic              arr_vld,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [TAG_W-1:0]  nx_tag,
  output logic              rd_idx,
  output logic [SEL_W-1:0]  rd_sel,
  output logic              iss_en,
  output logic              iss_idx,
  output logic [TAG_W-1:0]  iss_tag,
  output logic              fill_en,
  output logic              fill_idx,
  output logic              fill_keep,
  output logic              ack,
  output logic [BUS_W-1:0]  rdata,
  output logic              arr_rd,
  output logic [TAG_W-1:0]  arr_line,
  output logic              idle
);
  fpb_state_e        st_q;
  logic              ack_q;
  logic [BUS_W-1:0]  rdata_q;
  logic              busy_q;
  logic              dst_q;
  logic              stale_q;
  logic              lru_q;
  logic              arr_rd_q;
  logic [TAG_W-1:0]  arr_line_q;

  logic accept, do_hit, do_miss, serve, serve_idx, pf_go;
  logic unused_lo;

  assign unused_lo = ^addr[BYTE_W-1:0];

  assign lk_tag = addr[ADDR_W-1:OFS_W];
  assign nx_tag = lk_tag + TAG_W'(1);
  assign rd_sel = addr[OFS_W-1:BYTE_W];

  assign accept    = req && !ack_q && (st_q == ST_IDLE);
  assign do_hit    = accept && hit;
  assign do_miss   = accept && !hit && !busy_q;
  assign serve     = do_hit || (st_q == ST_REPLY);
  assign serve_idx = (st_q == ST_REPLY) ? dst_q : hit_idx;
  assign pf_go     = serve && pf_ok && !nx_hit && !busy_q;

  assign iss_en    = do_miss || pf_go;
  assign iss_idx   = do_miss ? lru_q : ~serve_idx;
  assign iss_tag   = do_miss ? lk_tag : nx_tag;
  assign fill_en   = busy_q && arr_vld;
  assign fill_idx  = dst_q;
  assign fill_keep = !stale_q && !inval;
  assign rd_idx    = serve_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      ack_q      <= 1'b0;
      rdata_q    <= '0;
      busy_q     <= 1'b0;
      dst_q      <= 1'b0;
      stale_q    <= 1'b0;
      lru_q      <= 1'b0;
      arr_rd_q   <= 1'b0;
      arr_line_q <= '0;
    end else begin
      ack_q    <= serve;
      arr_rd_q <= iss_en;
      if (serve) begin
        rdata_q <= rd_word;
        lru_q   <= ~serve_idx;
      end
      if (iss_en) begin
        arr_line_q <= iss_tag;
        busy_q     <= 1'b1;
        dst_q      <= iss_idx;
        stale_q    <= 1'b0;
      end else begin
        if (fill_en) busy_q <= 1'b0;
        if (inval && busy_q) stale_q <= 1'b1;
      end
      case (st_q)
        ST_IDLE:   if (do_miss) st_q <= ST_DEMAND;
        ST_DEMAND: if (fill_en) st_q <= ST_REPLY;
        ST_REPLY:  st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  assign ack      = ack_q;
  assign rdata    = rdata_q;
  assign arr_rd   = arr_rd_q;
  assign arr_line = arr_line_q;
  assign idle     = (st_q == ST_IDLE);
endmodule

// File: rtl/flash_line_prefetch.sv
module flash_line_prefetch
  import fpb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 64,
  parameter int LINE_W = 256,
  parameter int MID_W  = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  bus_req,
  input  logic [ADDR_W-1:0]                     bus_addr,
  input  logic [MID_W-1:0]                      bus_master,
  input  logic                                  bus_instr,
  output logic                                  bus_ack,
  output logic [BUS_W-1:0]                      bus_rdata,
  input  logic                                  pf_instr_en,
  input  logic                                  pf_data_en,
  input  logic                                  pf_one_master,
  input  logic [MID_W-1:0]                      pf_master_id,
  input  logic                                  inval,
  output logic                                  arr_rd,
  output logic [ADDR_W-$clog2(LINE_W/8)-1:0]    arr_line,
  input  logic                                  arr_valid,
  input  logic [LINE_W-1:0]                     arr_rdata
);
  localparam int OFS_W = $clog2(LINE_W/8);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int SEL_W = $clog2(LINE_W/BUS_W);

  logic [TAG_W-1:0] lk_tag, nx_tag, iss_tag;
  logic             lk_hit, hit_idx, nx_hit;
  logic             rd_idx;
  logic [SEL_W-1:0] rd_sel;
  logic [BUS_W-1:0] rd_word;
  logic             iss_en, iss_idx, fill_en, fill_idx, fill_keep;
  logic             pf_ok;
  logic             ctl_idle;
  logic [NBUF-1:0]  buf_vld;

  fpb_pf_filter #(.MID_W(MID_W)) u_filter (
    .master         (bus_master),
    .is_instr       (bus_instr),
    .cfg_instr_en   (pf_instr_en),
    .cfg_data_en    (pf_data_en),
    .cfg_one_master (pf_one_master),
    .cfg_master     (pf_master_id),
    .pf_ok          (pf_ok)
  );

  fpb_line_store #(.LINE_W(LINE_W), .BUS_W(BUS_W), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .lk_tag    (lk_tag),
    .nx_tag    (nx_tag),
    .hit       (lk_hit),
    .hit_idx   (hit_idx),
    .nx_hit    (nx_hit),
    .rd_idx    (rd_idx),
    .rd_sel    (rd_sel),
    .rd_word   (rd_word),
    .iss_en    (iss_en),
    .iss_idx   (iss_idx),
    .iss_tag   (iss_tag),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_keep (fill_keep),
    .fill_data (arr_rdata),
    .inval     (inval),
    .vld       (buf_vld)
  );

  fpb_seq_ctrl #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .LINE_W(LINE_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req       (bus_req),
    .addr      (bus_addr),
    .pf_ok     (pf_ok),
    .inval     (inval),
    .hit       (lk_hit),
    .hit_idx   (hit_idx),
    .nx_hit    (nx_hit),
    .rd_word   (rd_word),
    .arr_vld   (arr_valid),
    .lk_tag    (lk_tag),
    .nx_tag    (nx_tag),
    .rd_idx    (rd_idx),
    .rd_sel    (rd_sel),
    .iss_en    (iss_en),
    .iss_idx   (iss_idx),
    .iss_tag   (iss_tag),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_keep (fill_keep),
    .ack       (bus_ack),
    .rdata     (bus_rdata),
    .arr_rd    (arr_rd),
    .arr_line  (arr_line),
    .idle      (ctl_idle)
  );
endmodule

// File: rtl/fpb_checker.sv
module fpb_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_req,
  input logic       bus_ack,
  input logic       arr_rd,
  input logic       arr_valid,
  input logic       inval,
  input logic       lk_hit,
  input logic       ctl_idle,
  input logic [1:0] vld
);
  logic outstanding_q;

  always_ff @(posedge clk) begin
    if (rst) outstanding_q <= 1'b0;
    else if (arr_rd) outstanding_q <= 1'b1;
    else if (arr_valid) outstanding_q <= 1'b0;
  end

  assert_hit_zero_wait_R1: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack && ctl_idle && lk_hit |=> bus_ack);

  assert_inval_clears_R10: assert property (@(posedge clk) disable iff (rst)
    inval |=> (vld == 2'b00));

  assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (rst)
    arr_rd |-> !outstanding_q);
endmodule

bind flash_line_prefetch fpb_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .arr_rd    (arr_rd),
  .arr_valid (arr_valid),
  .inval     (inval),
  .lk_hit    (lk_hit),
  .ctl_idle  (ctl_idle),
  .vld       (buf_vld)
);

// File: tb/flash_line_prefetch_test.sv
module flash_line_prefetch_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         bus_req;
  logic [31:0]  bus_addr;
  logic [1:0]   bus_master;
  logic         bus_instr;
  logic         bus_ack;
  logic [63:0]  bus_rdata;
  logic         pf_instr_en, pf_data_en, pf_one_master;
  logic [1:0]   pf_master_id;
  logic         inval;
  logic         arr_rd;
  logic [26:0]  arr_line;
  logic         arr_valid = 1'b0;
  logic [255:0] arr_rdata = '0;
  logic [7:0]   epoch = 8'd0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  flash_line_prefetch uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_master(bus_master), .bus_instr(bus_instr), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .pf_instr_en(pf_instr_en), .pf_data_en(pf_data_en),
    .pf_one_master(pf_one_master), .pf_master_id(pf_master_id), .inval(inval),
    .arr_rd(arr_rd), .arr_line(arr_line), .arr_valid(arr_valid),
    .arr_rdata(arr_rdata)
  );

  function automatic logic [63:0] mk_word(logic [26:0] t, logic [1:0] w, logic [7:0] ep);
    return {ep, 27'd0, t, w};
  endfunction

  function automatic logic [255:0] mk_line(logic [26:0] t, logic [7:0] ep);
    logic [255:0] l;
    for (int w = 0; w < 4; w++) l[w*64 +: 64] = mk_word(t, 2'(w), ep);
    return l;
  endfunction

  // array model: one cycle from read strobe to data
  always @(posedge clk) begin
    arr_valid <= arr_rd;
    if (arr_rd) arr_rdata <= mk_line(arr_line, epoch);
  end

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_word(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, input logic [1:0] mid, input logic ins,
                         input bit gap, output int waits, output logic [63:0] d,
                         output int rds, output logic [26:0] ln);
    bit got = 0;
    int tmo = 0;
    bus_addr = a; bus_master = mid; bus_instr = ins; bus_req = 1'b1;
    waits = 0; rds = 0; ln = '0; d = '0;
    while (!got && tmo < 40) begin
      @(negedge clk);
      tmo++;
      if (arr_rd) begin rds++; ln = arr_line; end
      if (bus_ack) begin got = 1; d = bus_rdata; end
      else waits++;
    end
    bus_req = 1'b0;
    if (!got) check_int("R3 request timeout", 0, 1);
    if (gap) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (k == 0) check_int("R12 ack single pulse", int'(bus_ack), 0);
        if (arr_rd) begin rds++; ln = arr_line; end
      end
    end
  endtask

  task automatic pulse_inval();
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic        instr;
    logic [3:0]  waits;
    logic [3:0]  rds;
    logic [26:0] line;
  } vec_t;

  // R4 R5 R9: sequence over lines 0x80..0x82 with all prefetch enabled
  localparam vec_t TABLE [6] = '{
    '{32'h0000_1008, 1'b0, 4'd3, 4'd2, 27'h81},
    '{32'h0000_1030, 1'b1, 4'd0, 4'd1, 27'h82},
    '{32'h0000_1018, 1'b0, 4'd3, 4'd1, 27'h80},
    '{32'h0000_1020, 1'b1, 4'd0, 4'd1, 27'h82},
    '{32'h0000_1000, 1'b0, 4'd3, 4'd1, 27'h80},
    '{32'h0000_1028, 1'b1, 4'd0, 4'd1, 27'h82}
  };

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int w, r;
    logic [63:0] d;
    logic [26:0] ln;
    rst = 1'b1; bus_req = 1'b0; bus_addr = '0; bus_master = '0; bus_instr = 1'b0;
    pf_instr_en = 1'b1; pf_data_en = 1'b1; pf_one_master = 1'b0; pf_master_id = '0;
    inval = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_int("R11 no ack after reset", int'(bus_ack), 0);
    check_int("R11 no array read after reset", int'(arr_rd), 0);

    for (int i = 0; i < 6; i++) begin
      do_read(TABLE[i].addr, 2'd0, TABLE[i].instr, 1'b1, w, d, r, ln);
      check_int(TABLE[i].waits == 0 ? "R1 hit wait states" : "R3 miss wait states",
                w, int'(TABLE[i].waits));
      check_word("R2 word select", d, mk_word(TABLE[i].addr[31:5], TABLE[i].addr[4:3], epoch));
      check_int("R4 R5 array read count", r, int'(TABLE[i].rds));
      check_int("R9 last array line", int'(ln), int'(TABLE[i].line));
    end

    // R10: invalidate forces a miss and fresh data
    epoch = 8'd1;
    pulse_inval();
    do_read(32'h0000_1028, 2'd0, 1'b1, 1'b1, w, d, r, ln);
    check_int("R10 miss after invalidate", w, 3);
    check_word("R10 fresh data", d, mk_word(27'h81, 2'd1, epoch));
    check_int("R10 reads after invalidate", r, 2);

    // R6: single-master restriction
    pf_one_master = 1'b1; pf_master_id = 2'd2;
    pulse_inval();
    do_read(32'h0000_2000, 2'd1, 1'b0, 1'b1, w, d, r, ln);
    check_int("R6 other master no prefetch", r, 1);
    check_int("R6 other master line", int'(ln), 27'h100);
    do_read(32'h0000_3000, 2'd2, 1'b0, 1'b1, w, d, r, ln);
    check_int("R6 chosen master prefetch", r, 2);
    check_int("R6 chosen master line", int'(ln), 27'h181);

    // R7: access-type filters
    pf_one_master = 1'b0; pf_instr_en = 1'b1; pf_data_en = 1'b0;
    pulse_inval();
    do_read(32'h0000_4000, 2'd0, 1'b0, 1'b1, w, d, r, ln);
    check_int("R7 data blocked", r, 1);
    do_read(32'h0000_5000, 2'd0, 1'b1, 1'b1, w, d, r, ln);
    check_int("R7 instr allowed", r, 2);
    check_int("R7 instr prefetch line", int'(ln), 27'h281);
    pf_instr_en = 1'b0;
    do_read(32'h0000_6000, 2'd0, 1'b1, 1'b1, w, d, r, ln);
    check_int("R7 both disabled", r, 1);

    // R8: demand lookups meeting an in-flight prefetch
    pf_instr_en = 1'b1; pf_data_en = 1'b1;
    pulse_inval();
    do_read(32'h0000_7000, 2'd0, 1'b0, 1'b0, w, d, r, ln);
    check_int("R8 first miss waits", w, 3);
    do_read(32'h0000_7020, 2'd0, 1'b0, 1'b0, w, d, r, ln);
    check_int("R8 served from prefetch waits", w, 2);
    check_word("R8 served from prefetch data", d, mk_word(27'h381, 2'd0, epoch));
    check_int("R8 no second read of line", r, 1);
    check_int("R8 next prefetch line", int'(ln), 27'h382);
    do_read(32'h0000_8018, 2'd0, 1'b0, 1'b1, w, d, r, ln);
    check_int("R8 other line waits for fill", w, 5);
    check_word("R8 other line data", d, mk_word(27'h400, 2'd3, epoch));
    check_int("R8 other line reads", r, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule